// File: doc/BRIEF.md
# Paired GPIO Port Register Block

This block holds the configuration registers for two 8-bit general-purpose ports. Together the two ports act as one 16-bit port. Software reaches the registers over a simple valid/write/address/byte-enable bus. A byte lane can be written or read without touching the other lane.

From the stored bits the block drives per-pin pad controls: output enable, output value, pull enable, pull direction and drive strength. Each pin input passes through a two-flop synchronizer. The synchronized value feeds two places: the read-only input register, and the input path of an alternate peripheral.

A function-select bit decides what the peripheral sees. While the bit is set, the peripheral sees the live pin. Once the bit is cleared, the peripheral keeps the last value it saw.

Top module: `gpio_pair_regs`

## Requirements
- R1: After reset every output, direction, pull-enable, drive and select bit is 0. Every pad is an unpulled input with reduced drive, `periph_in` is 0 and `bus_rdata` is 0.
- R2: Direction bit 1 makes the pin an output (`pad_oe`=1) and bit 0 makes it an input. `pad_out` always carries the output-register bit.
- R3: On a pin whose direction is 0 and whose pull-enable bit is 1, `pad_pull_en` is 1. `pad_pull_up` then equals the output-register bit: 1 pulls up, 0 pulls down. On an output pin both pull signals are 0.
- R4: `pad_drive_full` follows the drive register: 1 gives full drive, 0 gives reduced drive.
- R5: Writing a function-select bit never changes the direction bit or `pad_oe`.
- R6: While a pin's select bit is 1, `periph_in` equals the pin value from two clock edges earlier.
- R7: While a pin's select bit is 0, `periph_in` keeps the synchronized pin value captured just before the bit was cleared.
- R8: A write with `bus_be`=11 updates all 16 bits. With `bus_be`=01 only bits 7:0 change, and with `bus_be`=10 only bits 15:8 change.
- R9: Address 0 is the input register. A read returns the pin levels after the two-flop synchronizer (0 low, 1 high), and writes to it have no effect.
- R10: Read data appears on `bus_rdata` one clock after the request and holds until the next read. With `bus_be`=01 or 10 the selected byte is returned in bits 7:0 and bits 15:8 are 0. Any other byte-enable value returns the whole word.
- R11: The register map is 0 input, 1 output, 2 direction, 3 pull enable, 4 drive, 5 select. Reads of addresses 6 and 7 return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request |
| bus_write | input | 1 | 1 write, 0 read |
| bus_addr | input | 3 | Register address |
| bus_be | input | 2 | Byte lane enables (bit 0 low port, bit 1 high port) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| pin_in | input | 16 | Pin levels from the pads |
| pad_oe | output | 16 | Output enable per pin |
| pad_out | output | 16 | Output value per pin |
| pad_pull_en | output | 16 | Pull resistor enable per pin |
| pad_pull_up | output | 16 | 1 selects pull-up, 0 pull-down |
| pad_drive_full | output | 16 | 1 full drive, 0 reduced |
| periph_in | output | 16 | Latched pin input to the alternate peripheral |

## Verification
The embedded assertions check several rules on every cycle. Byte-lane isolation of the pad controls is checked for each write. Writes to the input register and to unmapped addresses must leave the pads untouched. The peripheral input must track the pin two edges behind while selected and must stay frozen while deselected. The bench scenarios cover the rest: the register readback values, the pull direction and drive decode for specific configurations, byte-read formatting, and the synchronized readback of pin levels.

// File: rtl/gpio_pair_regs.sv
module gpio_pair_regs #(
  parameter int PW = 8,
  parameter int AW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  input  logic [1:0]      bus_be,
  input  logic [2*PW-1:0] bus_wdata,
  output logic [2*PW-1:0] bus_rdata,
  input  logic [2*PW-1:0] pin_in,
  output logic [2*PW-1:0] pad_oe,
  output logic [2*PW-1:0] pad_out,
  output logic [2*PW-1:0] pad_pull_en,
  output logic [2*PW-1:0] pad_pull_up,
  output logic [2*PW-1:0] pad_drive_full,
  output logic [2*PW-1:0] periph_in
);
  localparam int W = 2 * PW;
  localparam logic [AW-1:0] A_IN  = AW'(0);
  localparam logic [AW-1:0] A_OUT = AW'(1);
  localparam logic [AW-1:0] A_DIR = AW'(2);
  localparam logic [AW-1:0] A_PUL = AW'(3);
  localparam logic [AW-1:0] A_DRV = AW'(4);
  localparam logic [AW-1:0] A_SEL = AW'(5);

  logic [W-1:0] out_q, dir_q, pul_q, drv_q, sel_q;
  logic [W-1:0] sync0_q, sync1_q, hold_q;
  logic [W-1:0] lane_mask, rd_word;
  logic         wr_en, rd_en;

  assign wr_en     = bus_valid & bus_write;
  assign rd_en     = bus_valid & ~bus_write;
  assign lane_mask = {{PW{bus_be[1]}}, {PW{bus_be[0]}}};

  function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] wd,
                                         input logic [W-1:0] m);
    return (old & ~m) | (wd & m);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      pul_q <= '0;
      drv_q <= '0;
      sel_q <= '0;
    end else if (wr_en) begin
      case (bus_addr)
        A_OUT:   out_q <= merge(out_q, bus_wdata, lane_mask);
        A_DIR:   dir_q <= merge(dir_q, bus_wdata, lane_mask);
        A_PUL:   pul_q <= merge(pul_q, bus_wdata, lane_mask);
        A_DRV:   drv_q <= merge(drv_q, bus_wdata, lane_mask);
        A_SEL:   sel_q <= merge(sel_q, bus_wdata, lane_mask);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync0_q <= '0;
      sync1_q <= '0;
      hold_q  <= '0;
    end else begin
      sync0_q <= pin_in;
      sync1_q <= sync0_q;
      hold_q  <= (sync1_q & sel_q) | (hold_q & ~sel_q);
    end
  end

  assign periph_in = (sync1_q & sel_q) | (hold_q & ~sel_q);

  always_comb begin
    case (bus_addr)
      A_IN:    rd_word = sync1_q;
      A_OUT:   rd_word = out_q;
      A_DIR:   rd_word = dir_q;
      A_PUL:   rd_word = pul_q;
      A_DRV:   rd_word = drv_q;
      A_SEL:   rd_word = sel_q;
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (rd_en) begin
      case (bus_be)
        2'b01:   bus_rdata <= {{PW{1'b0}}, rd_word[PW-1:0]};
        2'b10:   bus_rdata <= {{PW{1'b0}}, rd_word[W-1:PW]};
        default: bus_rdata <= rd_word;
      endcase
    end
  end

  assign pad_oe         = dir_q;
  assign pad_out        = out_q;
  assign pad_pull_en    = pul_q & ~dir_q;
  assign pad_pull_up    = pul_q & ~dir_q & out_q;
  assign pad_drive_full = drv_q;

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R8
  hi_lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bus_be[1]) |=>
      $stable({pad_oe[W-1:PW], pad_out[W-1:PW], pad_pull_en[W-1:PW], pad_drive_full[W-1:PW]}));

  // R8
  lo_lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bus_be[0]) |=>
      $stable({pad_oe[PW-1:0], pad_out[PW-1:0], pad_pull_en[PW-1:0], pad_drive_full[PW-1:0]}));

  // R9 R11
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (bus_addr == A_IN || bus_addr > A_SEL)) |=>
      $stable({pad_oe, pad_out, pad_pull_en, pad_pull_up, pad_drive_full}));

  // R5
  sel_keeps_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == A_SEL) |=> $stable(pad_oe));

  // R6
  periph_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (((periph_in ^ $past(pin_in, 2)) & sel_q) == '0));

  // R7
  periph_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd3) |-> (((periph_in ^ $past(periph_in)) & ~sel_q & ~$past(sel_q)) == '0));
endmodule

// File: tb/gpio_pair_regs_tb.sv
module gpio_pair_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [1:0]  bus_be = '0;
  logic [15:0] bus_wdata = '0, pin_in = '0;
  logic [15:0] bus_rdata, pad_oe, pad_out, pad_pull_en, pad_pull_up, pad_drive_full, periph_in;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_pair_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull_en(pad_pull_en),
    .pad_pull_up(pad_pull_up), .pad_drive_full(pad_drive_full), .periph_in(periph_in)
  );

  // {addr, be, wdata, expected word readback}
  localparam logic [36:0] VEC [0:9] = '{
    {3'd1, 2'b11, 16'hA5C3, 16'hA5C3},  // R8 word
    {3'd1, 2'b01, 16'h00FF, 16'hA5FF},  // R8 low byte
    {3'd1, 2'b10, 16'h1200, 16'h12FF},  // R8 high byte
    {3'd2, 2'b10, 16'hF000, 16'hF000},
    {3'd2, 2'b01, 16'h000F, 16'hF00F},
    {3'd3, 2'b11, 16'hFFFF, 16'hFFFF},
    {3'd4, 2'b11, 16'h8001, 16'h8001},
    {3'd5, 2'b01, 16'h0033, 16'h0033},
    {3'd0, 2'b11, 16'hFFFF, 16'h0000},  // R9 read-only
    {3'd6, 2'b11, 16'h1234, 16'h0000}   // R11 unmapped
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [1:0] be, output logic [15:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    // R1
    check("R1 oe", pad_oe, 16'h0);
    check("R1 pull", pad_pull_en, 16'h0);
    check("R1 drive", pad_drive_full, 16'h0);
    check("R1 rdata", bus_rdata, 16'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) begin
      wr(VEC[i][36:34], VEC[i][33:32], VEC[i][31:16]);
      rd(VEC[i][36:34], 2'b11, r);
      check("R8/R9/R11 readback", r, VEC[i][15:0]);
    end
    check("R2 oe", pad_oe, 16'hF00F);
    check("R2 out", pad_out, 16'h12FF);
    check("R3 pull_en", pad_pull_en, 16'h0FF0);
    check("R3 pull_up", pad_pull_up, 16'h02F0);
    check("R4 drive", pad_drive_full, 16'h8001);
    check("R5 dir after select", pad_oe, 16'hF00F);
    // R10 byte reads
    rd(3'd1, 2'b10, r); check("R10 high byte", r, 16'h0012);
    rd(3'd1, 2'b01, r); check("R10 low byte", r, 16'h00FF);
    @(negedge clk); check("R10 hold", bus_rdata, 16'h00FF);
    // R9 input readback
    pin_in = 16'hBEEF;
    repeat (3) @(negedge clk);
    rd(3'd0, 2'b11, r); check("R9 input word", r, 16'hBEEF);
    rd(3'd0, 2'b10, r); check("R9/R10 input byte", r, 16'h00BE);
    // R6 follow
    pin_in = 16'h0030;
    repeat (3) @(negedge clk);
    check("R6 follow", periph_in & 16'h0033, 16'h0030);
    pin_in = 16'h0021;
    repeat (3) @(negedge clk);
    check("R6 follow change", periph_in & 16'h0033, 16'h0021);
    // R7 hold after deselect
    wr(3'd5, 2'b11, 16'h0000);
    pin_in = 16'h0012;
    repeat (4) @(negedge clk);
    check("R7 hold", periph_in & 16'h0033, 16'h0021);
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end
endmodule